// File: doc/BRIEF.md
# Single-Bit Logic Execution Unit

This unit executes the bit-granular logic instructions of a 32-bit integer pipeline. Each request names two source words and a bit position within each. The unit pulls one bit from each word at its position, combines the pair with a chosen Boolean function, and folds the result into a new destination word. It offers five families of operation: a plain form that writes a fresh single-bit result, two accumulating forms that merge the new bit into the destination's lowest bit, a shift form that pushes the new bit into the bottom of the destination, and an insert form (with an inverting variant) that places one bit into a copy of the first source at any position.

The instruction decoder upstream supplies the two source words, the current destination value, both positions and a 5-bit operation code, with a one-cycle request strobe. The result is registered. It comes back one clock later with a valid strobe and a flag that marks an unassigned operation code. The register file writes the result back.

Top module: `bitop_unit`

## Requirements
- R1: Plain forms (codes 0..7) write f(a,b) to bit 0 and clear bits 31..1, where a = src_a[pos_a] and b = src_b[pos_b]. The low three code bits pick f: 0 AND, 1 a AND NOT b, 2 NOR, 3 OR, 4 NAND, 5 a OR NOT b, 6 XNOR, 7 XOR.
- R2: AND-accumulate forms keep dst_in[31:1] and write dst_in[0] AND g into bit 0. The codes are 16 (g = a AND b), 17 (g = a AND NOT b), 18 (g = NOR(a,b)) and 19 (g = a OR b).
- R3: OR-accumulate forms keep dst_in[31:1] and write dst_in[0] OR g into bit 0. The codes are 20 (AND), 21 (a AND NOT b), 22 (NOR) and 23 (OR).
- R4: Shift forms (codes 8..15) compute f from the low three code bits, as in R1. The result is {dst_in[30:0], f}, and dst_in[31] is lost.
- R5: Code 24 returns src_a with bit pos_a replaced by b. Code 25 does the same but places NOT b.
- R6: pos_a and pos_b are independent, and each can select any of the 32 bit positions, including 0 and 31.
- R7: In the AND-NOT and OR-NOT functions, the inversion applies to the bit taken from src_b.
- R8: Codes 26..31 are illegal. They return dst_in unchanged and set res_illegal. A legal code clears res_illegal.
- R9: res_valid is high in the cycle after each cycle in which req_valid is high, and low otherwise. Without a request, res_data and res_illegal hold their values.
- R10: When rst_n is low, res_valid, res_data and res_illegal go to zero without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per operation |
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| dst_in | input | 32 | Current destination value |
| pos_a | input | 5 | Bit position in src_a (also the insert position) |
| pos_b | input | 5 | Bit position in src_b |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 32 | New destination value |
| res_illegal | output | 1 | Set when the last request used an unassigned code |

## Verification
The bench uses positions 0 and 31 on each source in turn. A picker that truncated or swapped the positions would then take the wrong bit. Paired AND-NOT and OR-NOT vectors whose answer changes with operand order catch a design that inverts the first-source bit instead of the second. Accumulate vectors whose upper destination bits are a pattern catch a design that clears them, and shift vectors with bit 31 set catch a design that rotates instead of shifting. Illegal codes and idle cycles catch a design that updates the destination when it must hold. An asynchronous reset pulse in mid-run catches reset logic that waits for a clock edge.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int OP_W = 5;

  // Boolean function applied to the pair (a from first source, b from second)
  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_ANDN = 3'd1,   // a & ~b
    FN_NOR  = 3'd2,
    FN_OR   = 3'd3,
    FN_NAND = 3'd4,
    FN_ORN  = 3'd5,   // a | ~b
    FN_XNOR = 3'd6,
    FN_XOR  = 3'd7
  } bit_fn_e;

  typedef enum logic [2:0] {
    FAM_PLAIN   = 3'd0,
    FAM_SHIFT   = 3'd1,
    FAM_ACC_AND = 3'd2,
    FAM_ACC_OR  = 3'd3,
    FAM_INSERT  = 3'd4,
    FAM_BAD     = 3'd5
  } bit_fam_e;

  typedef struct packed {
    bit_fam_e fam;
    bit_fn_e  fn;
    logic     invert;
  } bit_dec_t;

  // Code map boundaries
  localparam logic [OP_W-1:0] CODE_INSERT     = 5'd24;
  localparam logic [OP_W-1:0] CODE_INSERT_INV = 5'd25;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output bit_dec_t        dec_o
);

  always_comb begin
    dec_o.fam    = FAM_BAD;
    dec_o.fn     = FN_AND;
    dec_o.invert = 1'b0;
    unique case (op_i[4:3])
      2'b00: begin
        dec_o.fam = FAM_PLAIN;
        dec_o.fn  = bit_fn_e'(op_i[2:0]);
      end
      2'b01: begin
        dec_o.fam = FAM_SHIFT;
        dec_o.fn  = bit_fn_e'(op_i[2:0]);
      end
      2'b10: begin
        // inner function uses the first four entries: AND, ANDN, NOR, OR
        dec_o.fam = op_i[2] ? FAM_ACC_OR : FAM_ACC_AND;
        dec_o.fn  = bit_fn_e'({1'b0, op_i[1:0]});
      end
      default: begin
        if (op_i[2:1] == 2'b00) begin
          dec_o.fam    = FAM_INSERT;
          dec_o.invert = op_i[0];
        end
      end
    endcase
  end

endmodule

// File: rtl/bitop_pick.sv
module bitop_pick #(
  parameter int W     = 32,
  localparam int PW   = $clog2(W)
) (
  input  logic [W-1:0]  word_i,
  input  logic [PW-1:0] pos_i,
  output logic          bit_o
);

  assign bit_o = word_i[pos_i];

endmodule

// File: rtl/bitop_func.sv
module bitop_func
  import bitop_pkg::*;
(
  input  bit_fn_e fn_i,
  input  logic    a_i,
  input  logic    b_i,
  output logic    y_o
);

  always_comb begin
    unique case (fn_i)
      FN_AND:  y_o = a_i & b_i;
      FN_ANDN: y_o = a_i & ~b_i;
      FN_NOR:  y_o = ~(a_i | b_i);
      FN_OR:   y_o = a_i | b_i;
      FN_NAND: y_o = ~(a_i & b_i);
      FN_ORN:  y_o = a_i | ~b_i;
      FN_XNOR: y_o = ~(a_i ^ b_i);
      FN_XOR:  y_o = a_i ^ b_i;
      default: y_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bitop_compose.sv
module bitop_compose
  import bitop_pkg::*;
#(
  parameter int W   = 32,
  localparam int PW = $clog2(W)
) (
  input  bit_fam_e      fam_i,
  input  logic          fn_y_i,
  input  logic          b_bit_i,
  input  logic          invert_i,
  input  logic [W-1:0]  dst_i,
  input  logic [W-1:0]  src_a_i,
  input  logic [PW-1:0] pos_a_i,
  output logic [W-1:0]  word_o,
  output logic          illegal_o
);

  logic [W-1:0] ins_mask;
  logic         ins_bit;

  assign ins_mask = {{(W-1){1'b0}}, 1'b1} << pos_a_i;
  assign ins_bit  = b_bit_i ^ invert_i;

  always_comb begin
    word_o    = dst_i;
    illegal_o = 1'b0;
    unique case (fam_i)
      FAM_PLAIN:   word_o = {{(W-1){1'b0}}, fn_y_i};
      FAM_SHIFT:   word_o = {dst_i[W-2:0], fn_y_i};
      FAM_ACC_AND: word_o = {dst_i[W-1:1], dst_i[0] & fn_y_i};
      FAM_ACC_OR:  word_o = {dst_i[W-1:1], dst_i[0] | fn_y_i};
      FAM_INSERT:  word_o = (src_a_i & ~ins_mask) | ({W{ins_bit}} & ins_mask);
      default:     illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int W   = 32,
  localparam int PW = $clog2(W),
  localparam int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [W-1:0]    dst_in,
  input  logic [PW-1:0]   pos_a,
  input  logic [PW-1:0]   pos_b,
  output logic            res_valid,
  output logic [W-1:0]    res_data,
  output logic            res_illegal
);

  bit_dec_t     dec;
  logic [W-1:0] src_w   [NSRC];
  logic [PW-1:0] pos_w  [NSRC];
  logic         sel_bit [NSRC];
  logic         fn_y;
  logic [W-1:0] word_nx;
  logic         bad_nx;

  logic         valid_q;
  logic [W-1:0] data_q, data_d;
  logic         bad_q, bad_d;

  bitop_decode u_decode (
    .op_i  (op_sel),
    .dec_o (dec)
  );

  assign src_w[0] = src_a;
  assign src_w[1] = src_b;
  assign pos_w[0] = pos_a;
  assign pos_w[1] = pos_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_pick
    bitop_pick #(.W(W)) u_pick (
      .word_i (src_w[g]),
      .pos_i  (pos_w[g]),
      .bit_o  (sel_bit[g])
    );
  end

  bitop_func u_func (
    .fn_i (dec.fn),
    .a_i  (sel_bit[0]),
    .b_i  (sel_bit[1]),
    .y_o  (fn_y)
  );

  bitop_compose #(.W(W)) u_compose (
    .fam_i     (dec.fam),
    .fn_y_i    (fn_y),
    .b_bit_i   (sel_bit[1]),
    .invert_i  (dec.invert),
    .dst_i     (dst_in),
    .src_a_i   (src_a),
    .pos_a_i   (pos_a),
    .word_o    (word_nx),
    .illegal_o (bad_nx)
  );

  // next state: load only on an accepted request
  always_comb begin
    data_d = data_q;
    bad_d  = bad_q;
    if (req_valid) begin
      data_d = word_nx;
      bad_d  = bad_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      bad_q   <= 1'b0;
    end else begin
      valid_q <= req_valid;
      data_q  <= data_d;
      bad_q   <= bad_d;
    end
  end

  assign res_valid   = valid_q;
  assign res_data    = data_q;
  assign res_illegal = bad_q;

  // ---------------- assertions ----------------
  AST_PLAIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel[4:3] == 2'b00) |=> (res_data[W-1:1] == '0)); // R1

  AST_ACC_AND_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel[4:2] == 3'b100) |=>
      (res_data[W-1:1] == $past(dst_in[W-1:1])) && ($past(dst_in[0]) || !res_data[0])); // R2

  AST_ACC_OR_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel[4:2] == 3'b101) |=>
      (res_data[W-1:1] == $past(dst_in[W-1:1])) && (!$past(dst_in[0]) || res_data[0])); // R3

  AST_SHIFT_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel[4:3] == 2'b01) |=> (res_data[W-1:1] == $past(dst_in[W-2:0]))); // R4

  AST_INSERT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op_sel == CODE_INSERT || op_sel == CODE_INSERT_INV)) |=>
      ($countones(res_data ^ $past(src_a)) <= 1)); // R5

  AST_ILLEGAL_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel > CODE_INSERT_INV) |=> (res_illegal && res_data == $past(dst_in))); // R8

  AST_LEGAL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_sel <= CODE_INSERT_INV) |=> !res_illegal); // R8

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R9

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(res_data) && $stable(res_illegal))); // R9

endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
    logic [4:0]  pa;
    logic [4:0]  pb;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'd0,  32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 5'd31, 5'd0,  32'h0000_0001, 1'b0},
    '{5'd1,  32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 5'd0,  5'd0,  32'h0000_0000, 1'b0},
    '{5'd1,  32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 5'd0,  5'd0,  32'h0000_0001, 1'b0},
    '{5'd2,  32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 5'd3,  5'd17, 32'h0000_0001, 1'b0},
    '{5'd7,  32'h0000_0010, 32'h0000_0000, 32'h0000_0000, 5'd4,  5'd9,  32'h0000_0001, 1'b0},
    '{5'd6,  32'h0000_0010, 32'h0000_0000, 32'h0000_0000, 5'd4,  5'd9,  32'h0000_0000, 1'b0},
    '{5'd5,  32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 5'd0,  5'd0,  32'h0000_0000, 1'b0},
    '{5'd5,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 5'd0,  5'd0,  32'h0000_0001, 1'b0},
    '{5'd8,  32'h0000_0001, 32'h0000_0001, 32'h8000_0001, 5'd0,  5'd0,  32'h0000_0003, 1'b0},
    '{5'd15, 32'h0000_0001, 32'h0000_0001, 32'h1234_5678, 5'd0,  5'd0,  32'h2468_ACF0, 1'b0},
    '{5'd16, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 5'd0,  5'd0,  32'hFFFF_FFFE, 1'b0},
    '{5'd18, 32'h0000_0001, 32'h0000_0000, 32'hAAAA_AAAB, 5'd0,  5'd0,  32'hAAAA_AAAA, 1'b0},
    '{5'd22, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFE, 5'd0,  5'd0,  32'hFFFF_FFFF, 1'b0},
    '{5'd21, 32'h0000_0001, 32'h0000_0001, 32'h5555_5554, 5'd0,  5'd0,  32'h5555_5554, 1'b0},
    '{5'd24, 32'h0000_0000, 32'h8000_0000, 32'hDEAD_BEEF, 5'd31, 5'd31, 32'h8000_0000, 1'b0},
    '{5'd25, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 5'd0,  5'd0,  32'hFFFF_FFFE, 1'b0},
    '{5'd26, 32'h1111_1111, 32'h2222_2222, 32'hCAFE_F00D, 5'd5,  5'd6,  32'hCAFE_F00D, 1'b1},
    '{5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_1234, 5'd0,  5'd0,  32'h0000_1234, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [4:0]  op_sel;
  logic [31:0] src_a, src_b, dst_in;
  logic [4:0]  pos_a, pos_b;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_illegal;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .op_sel      (op_sel),
    .src_a       (src_a),
    .src_b       (src_b),
    .dst_in      (dst_in),
    .pos_a       (pos_a),
    .pos_b       (pos_b),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_illegal (res_illegal)
  );

  function automatic logic fn8(input logic [2:0] f, input logic a, input logic b);
    case (f)
      3'd0: return a & b;
      3'd1: return a & ~b;
      3'd2: return ~(a | b);
      3'd3: return a | b;
      3'd4: return ~(a & b);
      3'd5: return a | ~b;
      3'd6: return ~(a ^ b);
      default: return a ^ b;
    endcase
  endfunction

  // reference model written from the requirement list: {illegal, data}
  function automatic logic [32:0] ref_model(input logic [4:0] op, input logic [31:0] a_w,
      input logic [31:0] b_w, input logic [31:0] d_w, input logic [4:0] pa, input logic [4:0] pb);
    logic a, b, g;
    logic [31:0] r;
    a = a_w[pa];
    b = b_w[pb];
    if (op < 5'd8) begin
      r = 32'd0;
      r[0] = fn8(op[2:0], a, b);
    end else if (op < 5'd16) begin
      r = d_w << 1;
      r[0] = fn8(op[2:0], a, b);
    end else if (op < 5'd24) begin
      case (op[1:0])
        2'd0: g = a & b;
        2'd1: g = a & ~b;
        2'd2: g = ~(a | b);
        default: g = a | b;
      endcase
      r = d_w;
      r[0] = (op < 5'd20) ? (d_w[0] & g) : (d_w[0] | g);
    end else if (op == 5'd24) begin
      r = a_w;
      r[pa] = b;
    end else if (op == 5'd25) begin
      r = a_w;
      r[pa] = ~b;
    end else begin
      return {1'b1, d_w};
    end
    return {1'b0, r};
  endfunction

  function automatic string req_of(input logic [4:0] op);
    if (op < 5'd8)  return "R1";
    if (op < 5'd16) return "R4";
    if (op < 5'd20) return "R2";
    if (op < 5'd24) return "R3";
    if (op < 5'd26) return "R5";
    return "R8";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one request at a negedge, sample at the next negedge (one posedge later)
  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] d, input logic [4:0] pa, input logic [4:0] pb);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; dst_in = d; pos_a = pa; pos_b = pb;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [32:0] m;
    rst_n = 1'b0; req_valid = 1'b0; op_sel = '0;
    src_a = '0; src_b = '0; dst_in = '0; pos_a = '0; pos_b = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset valid",   {31'd0, res_valid},   32'd0);
    check("R10", "reset data",    res_data,             32'd0);
    check("R10", "reset illegal", {31'd0, res_illegal}, 32'd0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].d, VECS[i].pa, VECS[i].pb);
      check(req_of(VECS[i].op), "table data", res_data, VECS[i].exp);
      check("R8", "table illegal flag", {31'd0, res_illegal}, {31'd0, VECS[i].ill});
      check("R9", "table valid", {31'd0, res_valid}, 32'd1);
    end

    // R9: idle cycle -> strobe low, result held
    @(negedge clk);
    check("R9", "idle valid", {31'd0, res_valid}, 32'd0);
    check("R9", "idle data hold", res_data, 32'h0000_1234);
    check("R9", "idle illegal hold", {31'd0, res_illegal}, 32'd1);

    // R7: operand order of the inversion, both directions
    apply(5'd1, 32'h0, 32'h0, 32'h0, 5'd0, 5'd0);
    check("R7", "andn a=0 b=0", res_data, 32'h0);
    apply(5'd5, 32'h0, 32'hFFFF_FFFF, 32'h0, 5'd12, 5'd30);
    check("R7", "orn a=0 b=1", res_data, 32'h0);

    // R6: extreme positions, independent per source
    apply(5'd0, 32'h8000_0000, 32'h0000_0001, 32'h0, 5'd31, 5'd0);
    check("R6", "pos a=31 b=0", res_data, 32'h1);
    apply(5'd0, 32'h0000_0001, 32'h8000_0000, 32'h0, 5'd0, 5'd31);
    check("R6", "pos a=0 b=31", res_data, 32'h1);
    apply(5'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'h0, 5'd31, 5'd0);
    check("R6", "pos zeros at corners", res_data, 32'h0);
    apply(5'd25, 32'h0000_0000, 32'h0000_0000, 32'h0, 5'd31, 5'd31);
    check("R5", "inverted insert at 31", res_data, 32'h8000_0000);

    // random sweep of every code, corners first
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 24; k++) begin
        logic [31:0] a, b, d;
        logic [4:0]  pa, pb;
        a = $urandom; b = $urandom; d = $urandom;
        pa = 5'($urandom); pb = 5'($urandom);
        if (k == 0) begin pa = 5'd0;  pb = 5'd31; end
        if (k == 1) begin pa = 5'd31; pb = 5'd0;  end
        if (k == 2) begin pa = 5'd31; pb = 5'd31; end
        apply(5'(op), a, b, d, pa, pb);
        m = ref_model(5'(op), a, b, d, pa, pb);
        check(req_of(5'(op)), "random data", res_data, m[31:0]);
        check("R8", "random illegal flag", {31'd0, res_illegal}, {31'd0, m[32]});
      end
    end

    // R9: back-to-back requests, strobe stays high
    @(negedge clk);
    op_sel = 5'd3; src_a = 32'h1; src_b = 32'h0; dst_in = 32'h0; pos_a = 5'd0; pos_b = 5'd0;
    req_valid = 1'b1;
    @(negedge clk);
    check("R9", "b2b first", res_data, 32'h1);
    op_sel = 5'd4; src_a = 32'h1; src_b = 32'h1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "b2b second valid", {31'd0, res_valid}, 32'd1);
    check("R1", "b2b second data", res_data, 32'h0);

    // R10: asynchronous reset in mid-run
    apply(5'd23, 32'h1, 32'h1, 32'hFFFF_FFFF, 5'd0, 5'd0);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R10", "async clear data", res_data, 32'h0);
    check("R10", "async clear valid", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule